// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Sweep Engine

This block searches, in hardware, for the best receive sampling delay of a storage-card interface PHY. On a start pulse it walks a tune code upward from zero through a fixed number of steps. For every code it commits the code to the delay PHY twice, waiting each time for the PHY to drop a self-clearing update flag, and then asks an external tuning-command unit to run one tuning transfer and report pass or fail.

While sweeping, the engine tracks the longest run of consecutive passing codes. When the sweep ends it computes the centre of that run, commits the centre twice, and pulses done with the chosen code on its result port. If no code passed, it flags an error instead and programs nothing. A commit that the PHY never completes within a programmable number of cycles counts as a failed step. Producing the tuning command and checking its data pattern are done outside this block.

Top module: `tune_sweep_eng`

## Requirements
- R1: After a start, the codes committed are 0, 1, ..., NUM_STEPS-1 (0 to 39 by default) in ascending order. No code at or above NUM_STEPS is ever driven while the update flag is high.
- R2: A commit raises phy_upd_o with the code on phy_tune_o. The flag stays high until a one-cycle phy_clr_i pulse is seen, then it is low for at least one cycle.
- R3: Each code is committed COMMITS times (2 by default), each commit waiting for its own clear, before test_req_o rises. test_req_o is never high while phy_upd_o is high.
- R4: test_req_o stays high until test_ack_i is seen. test_pass_i is sampled in that same cycle (1 = pass).
- R5: A pass adds one to the current streak. A failed test or a failed commit sets the streak to zero. Only a streak strictly longer than the best so far replaces the best and records the present code as the end of the best run, so of equal runs the earliest one wins.
- R6: After the last step, when at least one pass occurred, the value end - floor(best/2) is committed COMMITS times. Then done_o pulses with final_o holding that value and err_o low.
- R7: If no step passed, err_o goes high together with a done_o pulse, and no final commit takes place.
- R8: If no clear arrives within timeout_i waiting cycles of a commit (timeout_i >= 1), phy_upd_o drops and the step counts as failed. A failed final commit raises err_o.
- R9: done_o is high for exactly one cycle per sweep. err_o holds until the next accepted start and reads 0 in the cycle after that start.
- R10: A start pulse received while a sweep is running is ignored: the sweep, its commits and its single done are unchanged.
- R11: After reset, done_o, err_o, phy_upd_o and test_req_o are 0 and final_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a sweep |
| timeout_i | input | TO_W | Maximum number of waiting cycles for one commit |
| phy_tune_o | output | TUNE_W | Tune code being committed to the PHY |
| phy_upd_o | output | 1 | Update flag; high while a commit is pending |
| phy_clr_i | input | 1 | PHY pulse that clears the update flag |
| test_req_o | output | 1 | Request for one tuning transfer |
| test_ack_i | input | 1 | Tuning transfer finished |
| test_pass_i | input | 1 | Result of the transfer, valid with test_ack_i |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| err_o | output | 1 | No passing code, or final commit failed |
| final_o | output | TUNE_W | Centre code chosen by the sweep |

## Verification
The assertions assume that the PHY pulses phy_clr_i only while phy_upd_o is high and that the command unit acknowledges only a pending request, with timeout_i held at a non-zero value during a sweep. The bench PHY model answers each commit after a random latency of 0 to 3 cycles, well inside the programmed timeout of 8. It never answers commits of codes marked stuck, which forces the timeout path. The test model acknowledges after 0 to 2 cycles with the result taken from a pass map. Random maps with varying density are mixed with directed maps: all pass, none pass, a single pass at either end, tied runs, a stuck run, and pass bits above the sweep range.

// File: rtl/tune_sweep_pkg.sv
package tune_sweep_pkg;
   typedef enum logic [2:0] {
      SW_IDLE,
      SW_COMMIT,
      SW_TEST,
      SW_ADV,
      SW_FINAL
   } sweep_st_e;

   typedef enum logic [1:0] {
      CM_IDLE,
      CM_WAIT,
      CM_GAP
   } commit_st_e;
endpackage

// File: rtl/tune_commit.sv
module tune_commit
   import tune_sweep_pkg::*;
#(
   parameter int TUNE_W  = 6,
   parameter int TO_W    = 8,
   parameter int COMMITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [TUNE_W-1:0] val_i,
   input  logic [TO_W-1:0]   timeout_i,
   input  logic              clr_i,
   output logic [TUNE_W-1:0] tune_o,
   output logic              upd_o,
   output logic              ok_o,
   output logic              fail_o
);
   localparam int PW = (COMMITS > 1) ? $clog2(COMMITS) : 1;

   generate
      if (COMMITS < 1) begin : g_bad_commits
         $error("tune_commit: COMMITS must be at least 1");
      end
   endgenerate

   commit_st_e        st;
   logic [TO_W-1:0]   tcnt;
   logic [PW-1:0]     pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= CM_IDLE;
         tune_o <= '0;
         upd_o  <= 1'b0;
         tcnt   <= '0;
         pcnt   <= '0;
         ok_o   <= 1'b0;
         fail_o <= 1'b0;
      end else begin
         ok_o   <= 1'b0;
         fail_o <= 1'b0;
         case (st)
            CM_IDLE: begin
               if (go_i) begin
                  tune_o <= val_i;
                  upd_o  <= 1'b1;
                  tcnt   <= '0;
                  pcnt   <= '0;
                  st     <= CM_WAIT;
               end
            end
            CM_WAIT: begin
               if (clr_i) begin
                  upd_o <= 1'b0;
                  tcnt  <= '0;
                  if (pcnt == PW'(COMMITS - 1)) begin
                     ok_o <= 1'b1;
                     st   <= CM_IDLE;
                  end else begin
                     pcnt <= pcnt + 1'b1;
                     st   <= CM_GAP;
                  end
               end else if (tcnt == timeout_i - 1'b1) begin
                  upd_o  <= 1'b0;
                  fail_o <= 1'b1;
                  st     <= CM_IDLE;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            CM_GAP: begin
               upd_o <= 1'b1;
               st    <= CM_WAIT;
            end
            default: st <= CM_IDLE;
         endcase
      end
   end

   AST_UPD_DROPS_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o && clr_i |=> !upd_o); // R2
   AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o && (timeout_i != '0) |-> tcnt < timeout_i); // R8
   AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |-> !fail_o && !upd_o); // R3
endmodule

// File: rtl/tune_streak.sv
module tune_streak #(
   parameter int TUNE_W = 6,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              hit_i,
   input  logic              miss_i,
   input  logic [TUNE_W-1:0] idx_i,
   output logic [CNT_W-1:0]  best_o,
   output logic [TUNE_W-1:0] end_o
);
   logic [CNT_W-1:0] cur;
   logic [CNT_W-1:0] cur_inc;

   assign cur_inc = cur + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= '0;
         best_o <= '0;
         end_o  <= '0;
      end else if (clear_i) begin
         cur    <= '0;
         best_o <= '0;
         end_o  <= '0;
      end else if (hit_i) begin
         cur <= cur_inc;
         if (cur_inc > best_o) begin
            best_o <= cur_inc;
            end_o  <= idx_i;
         end
      end else if (miss_i) begin
         cur <= '0;
      end
   end

   AST_BEST_NONDEC: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> best_o >= $past(best_o)); // R5
   AST_CUR_WITHIN_BEST: assert property (@(posedge clk) disable iff (!rst_n)
      cur <= best_o); // R5
   AST_TIE_KEEPS_END: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i && hit_i && (cur_inc <= best_o) |=> $stable(end_o)); // R5
endmodule

// File: rtl/tune_sweep_eng.sv
module tune_sweep_eng
   import tune_sweep_pkg::*;
#(
   parameter int TUNE_W    = 6,
   parameter int NUM_STEPS = 40,
   parameter int TO_W      = 8,
   parameter int COMMITS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [TO_W-1:0]   timeout_i,
   output logic [TUNE_W-1:0] phy_tune_o,
   output logic              phy_upd_o,
   input  logic              phy_clr_i,
   output logic              test_req_o,
   input  logic              test_ack_i,
   input  logic              test_pass_i,
   output logic              done_o,
   output logic              err_o,
   output logic [TUNE_W-1:0] final_o
);
   localparam int CNT_W = $clog2(NUM_STEPS + 1);
   localparam logic [TUNE_W-1:0] LAST = TUNE_W'(NUM_STEPS - 1);

   generate
      if (NUM_STEPS < 1 || NUM_STEPS > (1 << TUNE_W)) begin : g_bad_steps
         $error("tune_sweep_eng: NUM_STEPS must fit the tune code");
      end
   endgenerate

   sweep_st_e         st;
   logic [TUNE_W-1:0] idx;
   logic              cgo;
   logic [TUNE_W-1:0] cval;
   logic              c_ok, c_fail;
   logic              s_clear, s_hit, s_miss;
   logic [CNT_W-1:0]  s_best;
   logic [TUNE_W-1:0] s_end;
   logic [TUNE_W-1:0] centre;

   assign s_clear = (st == SW_IDLE) && start_i;
   assign s_hit   = (st == SW_TEST) && test_ack_i && test_pass_i;
   assign s_miss  = ((st == SW_COMMIT) && c_fail) ||
                    ((st == SW_TEST) && test_ack_i && !test_pass_i);
   assign centre  = s_end - TUNE_W'(s_best >> 1);

   tune_commit #(.TUNE_W(TUNE_W), .TO_W(TO_W), .COMMITS(COMMITS)) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (cgo),
      .val_i     (cval),
      .timeout_i (timeout_i),
      .clr_i     (phy_clr_i),
      .tune_o    (phy_tune_o),
      .upd_o     (phy_upd_o),
      .ok_o      (c_ok),
      .fail_o    (c_fail)
   );

   tune_streak #(.TUNE_W(TUNE_W), .CNT_W(CNT_W)) u_streak (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (s_clear),
      .hit_i   (s_hit),
      .miss_i  (s_miss),
      .idx_i   (idx),
      .best_o  (s_best),
      .end_o   (s_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SW_IDLE;
         idx        <= '0;
         cgo        <= 1'b0;
         cval       <= '0;
         test_req_o <= 1'b0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         final_o    <= '0;
      end else begin
         cgo    <= 1'b0;
         done_o <= 1'b0;
         case (st)
            SW_IDLE: begin
               if (start_i) begin
                  idx     <= '0;
                  err_o   <= 1'b0;
                  final_o <= '0;
                  cgo     <= 1'b1;
                  cval    <= '0;
                  st      <= SW_COMMIT;
               end
            end
            SW_COMMIT: begin
               if (c_fail) begin
                  st <= SW_ADV;
               end else if (c_ok) begin
                  test_req_o <= 1'b1;
                  st         <= SW_TEST;
               end
            end
            SW_TEST: begin
               if (test_ack_i) begin
                  test_req_o <= 1'b0;
                  st         <= SW_ADV;
               end
            end
            SW_ADV: begin
               if (idx == LAST) begin
                  if (s_best == '0) begin
                     err_o  <= 1'b1;
                     done_o <= 1'b1;
                     st     <= SW_IDLE;
                  end else begin
                     final_o <= centre;
                     cval    <= centre;
                     cgo     <= 1'b1;
                     st      <= SW_FINAL;
                  end
               end else begin
                  idx  <= idx + 1'b1;
                  cval <= idx + 1'b1;
                  cgo  <= 1'b1;
                  st   <= SW_COMMIT;
               end
            end
            SW_FINAL: begin
               if (c_ok || c_fail) begin
                  err_o  <= c_fail;
                  done_o <= 1'b1;
                  st     <= SW_IDLE;
               end
            end
            default: st <= SW_IDLE;
         endcase
      end
   end

   AST_TUNE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phy_upd_o |-> phy_tune_o <= LAST); // R1
   AST_NO_TEST_DURING_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      test_req_o |-> !phy_upd_o); // R3
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      test_req_o && !test_ack_i |=> test_req_o); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !start_i |=> err_o); // R9
endmodule

// File: tb/tune_sweep_eng_tb.sv
module tune_sweep_eng_tb;
   localparam int TUNE_W = 6;
   localparam int NSTEP  = 40;
   localparam int TO_W   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [TO_W-1:0]   timeout_i = 8'd8;
   logic [TUNE_W-1:0] phy_tune_o;
   logic              phy_upd_o;
   logic              phy_clr_i = 1'b0;
   logic              test_req_o;
   logic              test_ack_i = 1'b0;
   logic              test_pass_i = 1'b0;
   logic              done_o, err_o;
   logic [TUNE_W-1:0] final_o;

   int vecs = 0;
   int fails = 0;
   bit pass_map [64];
   bit stuck    [64];
   int commit_total = 0;
   int max_tune = 0;
   int done_cnt = 0;

   always #2 clk = ~clk;

   tune_sweep_eng u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_i(timeout_i),
      .phy_tune_o(phy_tune_o), .phy_upd_o(phy_upd_o), .phy_clr_i(phy_clr_i),
      .test_req_o(test_req_o), .test_ack_i(test_ack_i), .test_pass_i(test_pass_i),
      .done_o(done_o), .err_o(err_o), .final_o(final_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // PHY model: clears each commit after 0..3 cycles, never for stuck codes
   initial begin
      bit upd_prev = 1'b0;
      int lat = 0;
      int wcnt = 0;
      forever begin
         @(negedge clk);
         phy_clr_i = 1'b0;
         if (phy_upd_o && !upd_prev) begin
            commit_total++;
            if (int'(phy_tune_o) > max_tune) max_tune = int'(phy_tune_o);
            lat = $urandom % 4;
            wcnt = 0;
         end
         upd_prev = phy_upd_o;
         if (phy_upd_o && !stuck[phy_tune_o]) begin
            if (wcnt == lat) phy_clr_i = 1'b1;
            wcnt++;
         end
      end
   end

   // Tuning-command model: answers after 0..2 cycles from the pass map
   initial begin
      int tw = 0;
      int tlat = 0;
      forever begin
         @(negedge clk);
         test_ack_i = 1'b0;
         if (test_req_o) begin
            if (tw == tlat) begin
               test_ack_i  = 1'b1;
               test_pass_i = pass_map[phy_tune_o];
               tw = 0;
               tlat = $urandom % 3;
            end else begin
               tw++;
            end
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (done_o) done_cnt++;
      end
   end

   function automatic void model(output int best, output int endi, output int commits);
      int cur = 0;
      best = 0; endi = 0; commits = 0;
      for (int i = 0; i < NSTEP; i++) begin
         commits += stuck[i] ? 1 : 2;
         if (pass_map[i] && !stuck[i]) begin
            cur++;
            if (cur > best) begin best = cur; endi = i; end
         end else begin
            cur = 0;
         end
      end
      if (best > 0) commits += 2;
   endfunction

   task automatic clear_maps();
      for (int i = 0; i < 64; i++) begin pass_map[i] = 1'b0; stuck[i] = 1'b0; end
   endtask

   task automatic run(input string name, input bit poke_start);
      int best, endi, commits, n;
      model(best, endi, commits);
      done_cnt = 0; commit_total = 0; max_tune = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      check({name, " R9 err cleared after start"}, int'(err_o), 0);
      if (poke_start) begin
         repeat (50) @(negedge clk);
         start_i = 1'b1;            // R10: ignored while sweeping
         @(negedge clk); start_i = 1'b0;
      end
      n = 0;
      while (done_cnt == 0 && n < 20000) begin @(negedge clk); n++; end
      if (done_cnt == 0) begin
         fails++; vecs++;
         $display("FAIL %s R9 no done actual=0 expected=1", name);
      end
      check({name, " R7 err flag"}, int'(err_o), (best == 0) ? 1 : 0);
      if (best > 0)
         check({name, " R6 final centre"}, int'(final_o), endi - best / 2);
      repeat (6) @(negedge clk);
      check({name, " R9 R10 single done"}, done_cnt, 1);
      check({name, " R9 err held"}, int'(err_o), (best == 0) ? 1 : 0);
      check({name, " R3 R8 commit count"}, commit_total, commits);
      check({name, " R1 max code in range"}, int'(max_tune <= NSTEP - 1), 1);
   endtask

   initial begin
      repeat (250000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7311));
      clear_maps();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 done reset", int'(done_o), 0);
      check("R11 err reset", int'(err_o), 0);
      check("R11 upd reset", int'(phy_upd_o), 0);
      check("R11 req reset", int'(test_req_o), 0);
      check("R11 final reset", int'(final_o), 0);

      // R5 R6: every code passes, centre of 0..39
      for (int i = 0; i < NSTEP; i++) pass_map[i] = 1'b1;
      run("all_pass", 1'b0);
      // R7: nothing passes
      clear_maps();
      run("none_pass", 1'b0);
      // R9: err from previous run cleared by this start
      pass_map[0] = 1'b1;
      run("only_first", 1'b0);
      clear_maps(); pass_map[NSTEP-1] = 1'b1;
      run("only_last", 1'b0);
      // R5: equal runs 5..9 and 20..24, earliest kept
      clear_maps();
      for (int i = 5; i < 10; i++) pass_map[i] = 1'b1;
      for (int i = 20; i < 25; i++) pass_map[i] = 1'b1;
      run("tie_earliest", 1'b0);
      // R8: stuck commits at 10..12 break the streak
      clear_maps();
      for (int i = 0; i < NSTEP; i++) pass_map[i] = 1'b1;
      for (int i = 10; i < 13; i++) stuck[i] = 1'b1;
      run("stuck_mid", 1'b0);
      // R1 R10: pass bits above range are never visited; extra start ignored
      clear_maps();
      pass_map[0] = 1'b1; pass_map[1] = 1'b1;
      for (int i = NSTEP; i < 64; i++) pass_map[i] = 1'b1;
      run("above_range", 1'b1);
      // random maps
      for (int r = 0; r < 10; r++) begin
         int dens = 30 + ($urandom % 65);
         clear_maps();
         for (int i = 0; i < 64; i++) begin
            pass_map[i] = (($urandom % 100) < dens);
            stuck[i] = (($urandom % 100) < 5);
         end
         run("random", r[0]);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end
endmodule